// File: doc/BRIEF.md
# Angle-to-Quadrature Encoder Emulator

This block turns a 16-bit absolute shaft angle, as produced by a tracking converter, into the signals an incremental encoder and a set of Hall commutation sensors would give. An internal position count follows the angle one quadrature transition per clock, always along the shorter way round the circle. The count drives the quadrature pair A/B and a zero-position index Z, so a downstream counter sees a clean, glitch-free edge stream whose density depends only on the selected resolution and never on shaft speed.

The encoder resolution can be set to 12 through 16 bits. Changing it realigns the count at once to the present angle without replaying the distance as edges. The same angle, multiplied by the motor's pole-pair count, also selects one of six 60-degree electrical sectors. That sector is presented as the three-bit code a brushless motor's Hall sensors would give, for 4, 6 or 8 pole machines.

Top module: `angle_quad_emu`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs become `qa`=0, `qb`=0, `qz`=1 and `hall_u`/`hall_v`/`hall_w`=000, and the position count becomes 0.
- R2: Toward a target that differs from the count, the count moves in the direction of the shorter arc. It wraps modulo 2^N. When the two arcs are equal (difference exactly 2^(N-1)), it decrements.
- R3: `res_sel` codes 0,1,2,3,4 select N = 12,13,14,15,16 bits, and codes 5 to 7 act as 16 bits. The target is the top N bits of `angle`, so lower angle bits have no effect on the count.
- R4: `{qa,qb}` is 00, 01, 11, 10 for count modulo 4 equal to 0, 1, 2, 3. Outside a resynchronisation, A and B never change in the same cycle.
- R5: `qz` is high exactly while the count is zero, which is one transition wide on each pass through zero.
- R6: The count changes by at most one step per clock, at a constant rate regardless of the distance. A/B/Z show the count one cycle after it changes, so the first step of a move is visible two edges after the new angle is sampled.
- R7: `pole_sel` 0,1,2 select 2,3,4 pole pairs, and 3 acts as 4. The electrical angle is (angle × pairs) mod 2^16, and the sector is floor(electrical × 6 / 2^16). Sectors 0 to 5 give `{hall_u,hall_v,hall_w}` = 100, 110, 010, 011, 001, 101, one edge after the angle is sampled.
- R8: When the effective resolution changes, the count loads the new target in one clock, giving at most one A/B change and no run of intermediate edges. An unchanged effective resolution (for example code 4 to code 7) causes no resynchronisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| angle | input | 16 | Absolute angle, full scale = one revolution |
| res_sel | input | 3 | Encoder resolution code |
| pole_sel | input | 2 | Motor pole-count code |
| qa | output | 1 | Quadrature channel A |
| qb | output | 1 | Quadrature channel B |
| qz | output | 1 | Index, high at count zero |
| hall_u | output | 1 | Commutation output U |
| hall_v | output | 1 | Commutation output V |
| hall_w | output | 1 | Commutation output W |

## Verification
The quadrature outputs trail a new angle by two edges: one for the count step and one for the output register. Each further step then takes exactly one edge, and a resolution change lands in the same two edges. The commutation code trails the angle by a single edge. The bench changes inputs just after a falling edge and samples only at falling edges, and a monitor there classifies every A/B change as forward, backward or a jump and counts index rises. Each scenario waits enough falling edges to cover the full walk before it compares those counts. The rate check samples at an exact falling edge, where 40 steps must be visible after 41.

// File: rtl/aqe_pkg.sv
package aqe_pkg;

  localparam int ANGLE_W   = 16;
  localparam int RES_MIN   = 12;
  localparam int RES_CODES = 5;

  // Hall code for each 60-degree electrical sector, {u,v,w}
  function automatic logic [2:0] sector_code(input logic [2:0] sector);
    logic [2:0] c;
    case (sector)
      3'd0:    c = 3'b100;
      3'd1:    c = 3'b110;
      3'd2:    c = 3'b010;
      3'd3:    c = 3'b011;
      3'd4:    c = 3'b001;
      default: c = 3'b101;
    endcase
    return c;
  endfunction

  function automatic logic [2:0] pole_pairs(input logic [1:0] sel);
    logic [2:0] p;
    case (sel)
      2'd0:    p = 3'd2;
      2'd1:    p = 3'd3;
      default: p = 3'd4;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/aqe_tracker.sv
module aqe_tracker #(
  parameter int AW     = aqe_pkg::ANGLE_W,
  parameter int RMIN   = aqe_pkg::RES_MIN,
  parameter int RCODES = aqe_pkg::RES_CODES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] angle,
  input  logic [2:0]    res_sel,
  output logic [AW-1:0] cnt_o,
  output logic          resync_o
);

  localparam int SW = $clog2(AW);
  localparam int MAXSH = AW - RMIN;
  localparam logic [2:0] TOP_CODE = 3'(RCODES - 1);

  logic [2:0]    code_n, code_q;
  logic [SW-1:0] shamt, hbit;
  logic [AW-1:0] mask, target, diff, cnt_q;

  always_comb begin
    code_n = (res_sel > TOP_CODE) ? TOP_CODE : res_sel;
    shamt  = SW'(MAXSH) - SW'(code_n);
    hbit   = SW'(AW - 1) - shamt;
    mask   = {AW{1'b1}} >> shamt;
    target = angle >> shamt;
    diff   = (target - cnt_q) & mask;
  end

  assign resync_o = (code_n != code_q);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      code_q <= code_n;
    end else begin
      code_q <= code_n;
      if (resync_o)
        cnt_q <= target;
      else if (diff != '0)
        cnt_q <= diff[hbit] ? ((cnt_q - 1'b1) & mask) : ((cnt_q + 1'b1) & mask);
    end
  end

  // R6: outside a realignment the count moves by 0 or +/-1 modulo 2^N
  assert_single_step_R6: assert property (@(posedge clk) disable iff (rst)
    !resync_o |=> ((((cnt_q - $past(cnt_q)) & $past(mask)) == '0) ||
                   (((cnt_q - $past(cnt_q)) & $past(mask)) == AW'(1)) ||
                   (((cnt_q - $past(cnt_q)) & $past(mask)) == $past(mask))));

  // R2: once on target the count stays put
  assert_hold_on_target_R2: assert property (@(posedge clk) disable iff (rst)
    (!resync_o && diff == '0) |=> $stable(cnt_q));

  // R8: a resolution change lands the count on the new target in one clock
  assert_resync_load_R8: assert property (@(posedge clk) disable iff (rst)
    resync_o |=> (cnt_q == $past(target)));

endmodule

// File: rtl/aqe_quad.sv
module aqe_quad #(
  parameter int AW = aqe_pkg::ANGLE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cnt,
  output logic          qa,
  output logic          qb,
  output logic          qz
);

  always_ff @(posedge clk) begin
    if (rst) begin
      qa <= 1'b0;
      qb <= 1'b0;
      qz <= 1'b1;
    end else begin
      qa <= cnt[1];
      qb <= cnt[1] ^ cnt[0];
      qz <= (cnt == '0);
    end
  end

  // R5: index only appears in the 00 quadrature state
  assert_index_in_state0_R5: assert property (@(posedge clk) disable iff (rst)
    qz |-> (!qa && !qb));

endmodule

// File: rtl/aqe_hall.sv
module aqe_hall #(
  parameter int AW = aqe_pkg::ANGLE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] angle,
  input  logic [1:0]    pole_sel,
  output logic [2:0]    uvw
);

  logic [AW-1:0] elec;
  logic [AW+2:0] scaled;
  logic [2:0]    sector;
  logic          vld_q;

  always_comb begin
    elec   = angle * AW'(aqe_pkg::pole_pairs(pole_sel));
    scaled = {3'b000, elec} * (AW+3)'(6);
    sector = scaled[AW+2:AW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uvw   <= 3'b000;
      vld_q <= 1'b0;
    end else begin
      uvw   <= aqe_pkg::sector_code(sector);
      vld_q <= 1'b1;
    end
  end

  // R7: after the first clock out of reset only the six valid codes appear
  assert_hall_code_valid_R7: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> (uvw != 3'b000 && uvw != 3'b111));

endmodule

// File: rtl/angle_quad_emu.sv
module angle_quad_emu #(
  parameter int AW     = aqe_pkg::ANGLE_W,
  parameter int RMIN   = aqe_pkg::RES_MIN,
  parameter int RCODES = aqe_pkg::RES_CODES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] angle,
  input  logic [2:0]    res_sel,
  input  logic [1:0]    pole_sel,
  output logic          qa,
  output logic          qb,
  output logic          qz,
  output logic          hall_u,
  output logic          hall_v,
  output logic          hall_w
);

  logic [AW-1:0] cnt;
  logic          resync;
  logic [2:0]    uvw;

  aqe_tracker #(.AW(AW), .RMIN(RMIN), .RCODES(RCODES)) u_tracker (
    .clk(clk), .rst(rst), .angle(angle), .res_sel(res_sel),
    .cnt_o(cnt), .resync_o(resync)
  );

  aqe_quad #(.AW(AW)) u_quad (
    .clk(clk), .rst(rst), .cnt(cnt), .qa(qa), .qb(qb), .qz(qz)
  );

  aqe_hall #(.AW(AW)) u_hall (
    .clk(clk), .rst(rst), .angle(angle), .pole_sel(pole_sel), .uvw(uvw)
  );

  assign {hall_u, hall_v, hall_w} = uvw;

  // R4: no double change on A/B unless a realignment reached the outputs
  assert_gray_single_change_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(resync, 2) |-> !((qa != $past(qa)) && (qb != $past(qb))));

endmodule

// File: tb/angle_quad_emu_tb.sv
`timescale 1ns/1ps
module angle_quad_emu_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] angle = '0;
  logic [2:0]  res_sel = 3'd0;
  logic [1:0]  pole_sel = 2'd0;
  logic        qa, qb, qz, hall_u, hall_v, hall_w;

  int n_checks = 0;
  int n_fail   = 0;
  int n_fwd = 0, n_bwd = 0, n_jump = 0, n_zrise = 0;
  logic [1:0] prev_ab = 2'b00;
  logic       prev_z  = 1'b1;
  bit         done    = 0;

  always #5 clk = ~clk;

  angle_quad_emu u_dut (
    .clk(clk), .rst(rst), .angle(angle), .res_sel(res_sel), .pole_sel(pole_sel),
    .qa(qa), .qb(qb), .qz(qz), .hall_u(hall_u), .hall_v(hall_v), .hall_w(hall_w)
  );

  function automatic int ab_pos(input logic [1:0] ab);
    case (ab)
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [1:0] ab_of(input int c);
    case (c % 4)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic [2:0] hall_model(input int a, input int psel);
    int pp, e, s;
    pp = (psel == 0) ? 2 : (psel == 1) ? 3 : 4;
    e  = (a * pp) % 65536;
    s  = (e * 6) / 65536;
    case (s)
      0: return 3'b100;
      1: return 3'b110;
      2: return 3'b010;
      3: return 3'b011;
      4: return 3'b001;
      default: return 3'b101;
    endcase
  endfunction

  // edge monitor at falling edges
  always @(negedge clk) begin
    if (!rst) begin
      if ({qa, qb} != prev_ab) begin
        case ((ab_pos({qa, qb}) - ab_pos(prev_ab) + 4) % 4)
          1: n_fwd++;
          3: n_bwd++;
          default: n_jump++;
        endcase
      end
      if (qz && !prev_z) n_zrise++;
    end
    prev_ab = {qa, qb};
    prev_z  = qz;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic clear_mon();
    n_fwd = 0; n_bwd = 0; n_jump = 0; n_zrise = 0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(3);
    check(qa == 0 && qb == 0, "R1 ab", {qa, qb}, 0);
    check(qz == 1, "R1 z", qz, 1);
    check({hall_u, hall_v, hall_w} == 3'b000, "R1 hall", {hall_u, hall_v, hall_w}, 0);
    rst = 1'b0;
    step(2);
    clear_mon();
  endtask

  task automatic t_forward();
    angle = 16'd48;
    clear_mon();
    step(8);
    check(n_fwd == 3, "R4 forward steps", n_fwd, 3);
    check(n_bwd == 0 && n_jump == 0, "R4 no reverse", n_bwd + n_jump, 0);
    check({qa, qb} == 2'b10, "R4 final ab", {qa, qb}, 2'b10);
    check(qz == 0, "R5 z off", qz, 0);
  endtask

  task automatic t_wrap_back();
    angle = 16'hFFF0;
    clear_mon();
    step(10);
    check(n_bwd == 4 && n_fwd == 0, "R2 short way back", n_bwd, 4);
    check(n_zrise == 1, "R5 index pass", n_zrise, 1);
    check({qa, qb} == ab_of(4095), "R2 final ab", {qa, qb}, ab_of(4095));
  endtask

  task automatic t_wrap_fwd();
    angle = 16'd32;
    clear_mon();
    step(8);
    check(n_fwd == 3 && n_bwd == 0, "R2 short way forward", n_fwd, 3);
    check(n_zrise == 1, "R5 index pass fwd", n_zrise, 1);
    check({qa, qb} == 2'b11, "R4 final ab wrap", {qa, qb}, 2'b11);
  endtask

  task automatic t_truncate();
    angle = 16'd47;
    clear_mon();
    step(6);
    check(n_fwd + n_bwd + n_jump == 0, "R3 low bits ignored", n_fwd + n_bwd + n_jump, 0);
  endtask

  task automatic t_tie();
    angle = 16'd32 + 16'h8000;
    clear_mon();
    step(2060);
    check(n_bwd == 2048 && n_fwd == 0, "R2 half-circle decrements", n_bwd, 2048);
    check(n_zrise == 1, "R5 index on tie walk", n_zrise, 1);
    check({qa, qb} == ab_of(2050), "R2 tie final ab", {qa, qb}, ab_of(2050));
  endtask

  task automatic t_rate();
    angle = 16'(2150 * 16);
    clear_mon();
    step(41);
    check(n_fwd == 40, "R6 one step per clock", n_fwd, 40);
    step(70);
    check(n_fwd == 100 && n_jump == 0, "R6 total steps", n_fwd, 100);
  endtask

  task automatic t_resync16();
    res_sel = 3'd4;
    clear_mon();
    step(6);
    check(n_fwd + n_bwd + n_jump == 1, "R8 single change on resync", n_fwd + n_bwd + n_jump, 1);
    check({qa, qb} == ab_of(34400), "R8 resync ab", {qa, qb}, ab_of(34400));
    angle = 16'd34405;
    clear_mon();
    step(9);
    check(n_fwd == 5, "R3 16-bit steps", n_fwd, 5);
    check({qa, qb} == ab_of(34405), "R3 16-bit ab", {qa, qb}, ab_of(34405));
  endtask

  task automatic t_code_alias();
    res_sel = 3'd7;
    clear_mon();
    step(5);
    check(n_fwd + n_bwd + n_jump == 0, "R8 alias no resync", n_fwd + n_bwd + n_jump, 0);
    angle = 16'd34406;
    step(5);
    check(n_fwd == 1, "R3 code 7 is 16 bits", n_fwd, 1);
  endtask

  task automatic t_resync13();
    res_sel = 3'd1;
    clear_mon();
    step(6);
    check(n_fwd + n_bwd + n_jump <= 1, "R8 resync 13", n_fwd + n_bwd + n_jump, 1);
    check({qa, qb} == ab_of(4300), "R3 13-bit target", {qa, qb}, ab_of(4300));
    angle = 16'd34406 + 16'd16;
    clear_mon();
    step(6);
    check(n_fwd == 2, "R3 13-bit steps", n_fwd, 2);
  endtask

  task automatic t_hall();
    int angs[6] = '{0, 5000, 11000, 20000, 40000, 65535};
    for (int p = 0; p < 4; p++) begin
      pole_sel = 2'(p);
      for (int k = 0; k < 6; k++) begin
        angle = 16'(angs[k]);
        step(2);
        check({hall_u, hall_v, hall_w} == hall_model(angs[k], p), "R7 hall code",
              {hall_u, hall_v, hall_w}, hall_model(angs[k], p));
      end
    end
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    step(1);
    t_reset();
    t_forward();
    t_wrap_back();
    t_wrap_fwd();
    t_truncate();
    t_tie();
    t_rate();
    t_resync16();
    t_code_alias();
    t_resync13();
    t_hall();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule